// File: doc/BRIEF.md
# Demand/Burst Conversion Sequencer

This block is the supervisory controller that sits between a byte-wide serial port and a 10-bit successive-approximation converter. The serial port hands it configuration command bytes. Each command selects the input channel, the reference source, the gain and the run mode. The block drives the converter through a start/done handshake. For every conversion it emits a two-byte result packet on a valid/ready byte stream. Each result byte carries fixed guard bits, and the high byte also carries the channel the result came from. The command echo always goes out ahead of data that has not yet begun.

There are two run modes. In demand mode, each command yields one conversion. In burst mode, conversions repeat back to back until a new command changes the setting.

A new command never disturbs a conversion already in flight. It waits in a pending slot and is applied when the converter is free. If the byte stream stalls, the block keeps only the newest result. A half-sent packet is always completed with its own low byte.

An active-low reset input, together with a power-on hold of `POR_CYCLES` clocks after it is released, returns the block to idle with the default configuration.

Top module: `conv_sequencer`

## Requirements
- R1: A command byte is accepted only when its bits 7:6 are `11`. Any other byte causes no echo, no conversion and no configuration change.
- R2: After reset the configuration is all ones. The outputs are `chan_sel`=`11`, `ref_supply`=1 and `gain_unity`=1, with no conversion started and no response byte offered.
- R3: The command fields are decoded as follows, and bit 2 has no effect on them:
  - bits 5:4 drive `chan_sel` (`00`, `01`, `10` select inputs 0 to 2);
  - bit 3 drives `ref_supply` (1 = supply, 0 = external);
  - bit 0 drives `gain_unity` (1 = unity, 0 = half).
- R4: With bit 1 = 1 (demand), an accepted command with channel `00` to `10` produces exactly one `conv_start` pulse and the bytes echo, high, low.
- R5: The high byte is {`10`, channel tag, result[9:6]}. The low byte is {`0`, result[5:0], `0`}. The tag is the channel in force when that conversion started.
- R6: A command with channel `11` is echoed and becomes the configuration, but no conversion is started.
- R7: With bit 1 = 0 (burst), each `conv_done` is followed in the next cycle by a new `conv_start`, and every conversion yields a packet.
- R8: A command that arrives while a conversion is in flight lets that conversion finish and deliver its packet with the old tag. The new setting is applied afterwards, so a demand or channel-`11` command ends a burst.
- R9: The echo precedes any packet whose high byte has not been presented. Once a high byte is accepted, the next byte presented is its low byte.
- R10: While the stream is stalled, a newer result replaces the pending packet. A high byte is never followed by the low byte of another conversion.
- R11: `rsp_byte` stays stable while `rsp_valid` is high and `rsp_ready` is low.
- R12: For `POR_CYCLES` clocks after `rst_n` rises, the block stays in reset and ignores commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a received command byte |
| cmd_byte | input | 8 | Received command byte |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Consumer takes the response byte |
| rsp_byte | output | 8 | Response byte: echo, result high or result low |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | RES_W | Conversion result, valid with `conv_done` |
| chan_sel | output | 2 | Selected input channel |
| ref_supply | output | 1 | 1 = supply reference, 0 = external reference |
| gain_unity | output | 1 | 1 = unity gain, 0 = half gain |

## Verification
Some rules are checked by assertions on every cycle:
- the output byte holds steady under back-pressure;
- an accepted high byte is followed directly by its low byte;
- a pending command is never dropped before it is applied;
- no conversion ever starts on the unused channel.

Other behaviour only the bench's scenarios can show:
- the exact byte contents across the whole channel, reference and gain sweep;
- the count of starts per demand command;
- the order of echo and packets around a mode change;
- which result survives a stall;
- the power-on hold after reset release.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {K_ECHO, K_HI, K_LO} kind_e;

   localparam logic [1:0] CH_NONE   = 2'b11;
   localparam logic [7:0] CFG_RESET = 8'hFF;
   localparam logic [1:0] CMD_TAG   = 2'b11;

   typedef struct packed {
      logic [1:0] chan;
      logic       ref_sup;
      logic       demand;
      logic       gain_unity;
   } cfg_t;

   function automatic cfg_t decode_cmd(input logic [7:0] b);
      cfg_t c;
      c.chan       = b[5:4];
      c.ref_sup    = b[3];
      c.demand     = b[1];
      c.gain_unity = b[0];
      return c;
   endfunction

   function automatic logic [7:0] pack_hi(input logic [1:0] tag, input logic [9:0] r);
      return {2'b10, tag, r[9:6]};
   endfunction

   function automatic logic [7:0] pack_lo(input logic [9:0] r);
      return {1'b0, r[5:0], 1'b0};
   endfunction

endpackage

// File: rtl/seq_por.sv
module seq_por #(
   parameter int POR_CYCLES = 30000
) (
   input  logic clk,
   input  logic rst_n,
   output logic sys_rst_n
);
   if (POR_CYCLES < 0) begin : g_bad_por
      $error("POR_CYCLES must not be negative");
   end

   if (POR_CYCLES == 0) begin : g_no_hold
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= 1'b1;
      end
      assign sys_rst_n = q;
   end else begin : g_hold
      localparam int CW = $clog2(POR_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);
      logic [CW-1:0] cnt_q;
      logic          rel_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
         end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            rel_q <= 1'b1;
         end
      end
      assign sys_rst_n = rel_q;
   end
endmodule

// File: rtl/seq_cfg.sv
module seq_cfg
   import seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid_i,
   input  logic [7:0] cmd_byte_i,
   input  logic       apply_i,
   output cfg_t       cfg_o,
   output cfg_t       pend_o,
   output logic       pend_v_o,
   output logic       echo_load_o,
   output logic [7:0] echo_byte_o
);
   cfg_t cfg_q, pend_q;
   logic pend_v_q;
   logic accepted;

   assign accepted    = cmd_valid_i && (cmd_byte_i[7:6] == CMD_TAG);
   assign echo_load_o = accepted;
   assign echo_byte_o = cmd_byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= decode_cmd(CFG_RESET);
         pend_q   <= decode_cmd(CFG_RESET);
         pend_v_q <= 1'b0;
      end else begin
         if (apply_i) cfg_q <= pend_q;
         if (accepted) begin
            pend_q   <= decode_cmd(cmd_byte_i);
            pend_v_q <= 1'b1;
         end else if (apply_i) begin
            pend_v_q <= 1'b0;
         end
      end
   end

   assign cfg_o    = cfg_q;
   assign pend_o   = pend_q;
   assign pend_v_o = pend_v_q;

   // R8: a queued command survives until the controller applies it
   a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v_q && !apply_i |=> pend_v_q);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seq_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_chan_i,
   input  logic             cfg_demand_i,
   input  logic [1:0]       pend_chan_i,
   input  logic             pend_demand_i,
   input  logic             pend_v_i,
   output logic             apply_o,
   output logic             conv_start_o,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_result_i,
   output logic             res_load_o,
   output logic [RES_W-1:0] res_data_o,
   output logic [1:0]       res_tag_o
);
   typedef enum logic {S_IDLE, S_BUSY} st_e;

   st_e        state_q, state_d;
   logic       start_q, start_d;
   logic [1:0] tag_q;
   logic [1:0] nxt_chan;
   logic       nxt_demand;
   logic       ch_ok;

   assign apply_o    = pend_v_i && ((state_q == S_IDLE) || conv_done_i);
   assign nxt_chan   = apply_o ? pend_chan_i   : cfg_chan_i;
   assign nxt_demand = apply_o ? pend_demand_i : cfg_demand_i;
   assign ch_ok      = (nxt_chan != CH_NONE);

   always_comb begin
      state_d    = state_q;
      start_d    = 1'b0;
      res_load_o = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (apply_o && ch_ok) begin
               start_d = 1'b1;
               state_d = S_BUSY;
            end
         end
         S_BUSY: begin
            if (conv_done_i) begin
               res_load_o = 1'b1;
               if (ch_ok && (apply_o || !nxt_demand)) start_d = 1'b1;
               else                                   state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         start_q <= 1'b0;
         tag_q   <= CH_NONE;
      end else begin
         state_q <= state_d;
         start_q <= start_d;
         if (start_d) tag_q <= nxt_chan;
      end
   end

   assign conv_start_o = start_q;
   assign res_data_o   = conv_result_i;
   assign res_tag_o    = tag_q;

   // R6: the unused channel code never launches a conversion
   a_r6_no_unused_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> (tag_q != CH_NONE));
endmodule

// File: rtl/seq_rsp.sv
module seq_rsp
   import seq_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             echo_load_i,
   input  logic [7:0]       echo_byte_i,
   input  logic             res_load_i,
   input  logic [RES_W-1:0] res_data_i,
   input  logic [1:0]       res_tag_i,
   input  logic             rsp_ready_i,
   output logic             rsp_valid_o,
   output logic [7:0]       rsp_byte_o
);
   logic             echo_v_q, echo_v_d;
   logic [7:0]       echo_q, echo_d;
   logic             slot_v_q, slot_v_d, slot_hi_q, slot_hi_d;
   logic [RES_W-1:0] slot_r_q, slot_r_d;
   logic [1:0]       slot_t_q, slot_t_d;
   logic             nxt_v_q, nxt_v_d;
   logic [RES_W-1:0] nxt_r_q, nxt_r_d;
   logic [1:0]       nxt_t_q, nxt_t_d;
   logic             out_v_q, out_v_d;
   logic [7:0]       out_q, out_d;
   kind_e            out_k_q, out_k_d;

   logic             sel_v, take;
   kind_e            sel_k;
   logic [7:0]       sel_b;

   always_comb begin
      sel_v = 1'b1;
      sel_k = K_ECHO;
      sel_b = echo_q;
      if (slot_v_q && slot_hi_q) begin
         sel_k = K_LO;
         sel_b = pack_lo(slot_r_q);
      end else if (echo_v_q) begin
         sel_k = K_ECHO;
         sel_b = echo_q;
      end else if (slot_v_q) begin
         sel_k = K_HI;
         sel_b = pack_hi(slot_t_q, slot_r_q);
      end else begin
         sel_v = 1'b0;
      end
   end

   assign take = sel_v && (!out_v_q || rsp_ready_i);

   always_comb begin
      echo_v_d  = echo_v_q;  echo_d   = echo_q;
      slot_v_d  = slot_v_q;  slot_hi_d = slot_hi_q;
      slot_r_d  = slot_r_q;  slot_t_d = slot_t_q;
      nxt_v_d   = nxt_v_q;   nxt_r_d  = nxt_r_q;  nxt_t_d = nxt_t_q;
      out_v_d   = out_v_q;   out_d    = out_q;    out_k_d = out_k_q;

      if (take) begin
         out_v_d = 1'b1;
         out_d   = sel_b;
         out_k_d = sel_k;
         case (sel_k)
            K_ECHO: echo_v_d = 1'b0;
            K_HI:   slot_hi_d = 1'b1;
            K_LO: begin
               slot_hi_d = 1'b0;
               if (nxt_v_q) begin
                  slot_r_d = nxt_r_q;
                  slot_t_d = nxt_t_q;
                  nxt_v_d  = 1'b0;
               end else begin
                  slot_v_d = 1'b0;
               end
            end
            default: ;
         endcase
      end else if (rsp_ready_i) begin
         out_v_d = 1'b0;
      end

      if (echo_load_i) begin
         echo_v_d = 1'b1;
         echo_d   = echo_byte_i;
      end

      if (res_load_i) begin
         if (slot_v_d && slot_hi_d) begin
            nxt_v_d = 1'b1;
            nxt_r_d = res_data_i;
            nxt_t_d = res_tag_i;
         end else begin
            slot_v_d  = 1'b1;
            slot_hi_d = 1'b0;
            slot_r_d  = res_data_i;
            slot_t_d  = res_tag_i;
            nxt_v_d   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         echo_v_q <= 1'b0;  echo_q   <= '0;
         slot_v_q <= 1'b0;  slot_hi_q <= 1'b0;
         slot_r_q <= '0;    slot_t_q <= '0;
         nxt_v_q  <= 1'b0;  nxt_r_q  <= '0;  nxt_t_q <= '0;
         out_v_q  <= 1'b0;  out_q    <= '0;  out_k_q <= K_ECHO;
      end else begin
         echo_v_q <= echo_v_d;  echo_q   <= echo_d;
         slot_v_q <= slot_v_d;  slot_hi_q <= slot_hi_d;
         slot_r_q <= slot_r_d;  slot_t_q <= slot_t_d;
         nxt_v_q  <= nxt_v_d;   nxt_r_q  <= nxt_r_d;  nxt_t_q <= nxt_t_d;
         out_v_q  <= out_v_d;   out_q    <= out_d;    out_k_q <= out_k_d;
      end
   end

   assign rsp_valid_o = out_v_q;
   assign rsp_byte_o  = out_q;

   // R11: a byte on offer does not change until it is taken
   a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      out_v_q && !rsp_ready_i |=> out_v_q && $stable(out_q));

   // R9: an accepted high byte is immediately followed by its low byte
   a_r9_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
      out_v_q && rsp_ready_i && (out_k_q == K_HI) |=> out_v_q && (out_k_q == K_LO));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import seq_pkg::*;
#(
   parameter int RES_W      = 10,
   parameter int POR_CYCLES = 30000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_byte,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [7:0]       rsp_byte,
   output logic             conv_start,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_result,
   output logic [1:0]       chan_sel,
   output logic             ref_supply,
   output logic             gain_unity
);
   localparam int PKT_RES_W = 10;

   if (RES_W != PKT_RES_W) begin : g_bad_width
      $error("result packet format carries exactly 10 result bits");
   end

   logic             sys_rst_n;
   cfg_t             cfg, pend;
   logic             pend_v, apply;
   logic             echo_load;
   logic [7:0]       echo_byte;
   logic             res_load;
   logic [RES_W-1:0] res_data;
   logic [1:0]       res_tag;

   seq_por #(.POR_CYCLES(POR_CYCLES)) i_por (
      .clk       (clk),
      .rst_n     (rst_n),
      .sys_rst_n (sys_rst_n)
   );

   seq_cfg i_cfg (
      .clk         (clk),
      .rst_n       (sys_rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_byte_i  (cmd_byte),
      .apply_i     (apply),
      .cfg_o       (cfg),
      .pend_o      (pend),
      .pend_v_o    (pend_v),
      .echo_load_o (echo_load),
      .echo_byte_o (echo_byte)
   );

   seq_ctrl #(.RES_W(RES_W)) i_ctrl (
      .clk           (clk),
      .rst_n         (sys_rst_n),
      .cfg_chan_i    (cfg.chan),
      .cfg_demand_i  (cfg.demand),
      .pend_chan_i   (pend.chan),
      .pend_demand_i (pend.demand),
      .pend_v_i      (pend_v),
      .apply_o       (apply),
      .conv_start_o  (conv_start),
      .conv_done_i   (conv_done),
      .conv_result_i (conv_result),
      .res_load_o    (res_load),
      .res_data_o    (res_data),
      .res_tag_o     (res_tag)
   );

   seq_rsp #(.RES_W(RES_W)) i_rsp (
      .clk         (clk),
      .rst_n       (sys_rst_n),
      .echo_load_i (echo_load),
      .echo_byte_i (echo_byte),
      .res_load_i  (res_load),
      .res_data_i  (res_data),
      .res_tag_i   (res_tag),
      .rsp_ready_i (rsp_ready),
      .rsp_valid_o (rsp_valid),
      .rsp_byte_o  (rsp_byte)
   );

   assign chan_sel   = cfg.chan;
   assign ref_supply = cfg.ref_sup;
   assign gain_unity = cfg.gain_unity;

   // R2: nothing is offered or started while the internal reset holds
   a_r2_quiet_in_reset: assert property (@(posedge clk)
      !sys_rst_n |-> !rsp_valid && !conv_start);
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
   localparam int POR = 40;
   localparam int CONV_CYC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       rsp_valid, rsp_ready;
   logic [7:0] rsp_byte;
   logic       conv_start;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = '0;
   logic [1:0] chan_sel;
   logic       ref_supply, gain_unity;

   always #5 clk = ~clk;

   conv_sequencer #(.RES_W(10), .POR_CYCLES(POR)) i_conv_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
      .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
      .chan_sel(chan_sel), .ref_supply(ref_supply), .gain_unity(gain_unity));

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int cyc = 0;
   int ready_mode = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      case (ready_mode)
         0: rsp_ready = 1'b1;
         1: rsp_ready = 1'b0;
         default: rsp_ready = ((cyc % 7) < 3);
      endcase
   end

   logic [7:0] rx [0:1023];
   int rx_n = 0;
   int n_starts = 0;
   int restart_gap_bad = 0;
   int prod [0:1023];

   function automatic int val_of(int k);
      if (k == 0) return 0;
      if (k == 1) return 1023;
      return (k * 389 + 5) % 1024;
   endfunction

   function automatic int hi_exp(int ch, int v);
      return 128 + ch * 16 + (v / 64);
   endfunction

   function automatic int lo_exp(int v);
      return (v % 64) * 2;
   endfunction

   always @(negedge clk) begin
      if (rsp_valid && rsp_ready && rx_n < 1024) begin
         rx[rx_n] = rsp_byte;
         rx_n++;
      end
   end

   bit in_burst = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            int k;
            k = n_starts;
            n_starts++;
            prod[k] = val_of(k);
            repeat (CONV_CYC) @(posedge clk);
            #1 conv_done = 1'b1;
            conv_result = 10'(prod[k]);
            @(posedge clk);
            #1 conv_done = 1'b0;
            @(negedge clk);
            if (in_burst && !conv_start) restart_gap_bad++;
            if (conv_start) begin
               int k2;
               k2 = n_starts;
               n_starts++;
               prod[k2] = val_of(k2);
               repeat (CONV_CYC - 1) @(posedge clk);
               #1 conv_done = 1'b1;
               conv_result = 10'(prod[k2]);
               @(posedge clk);
               #1 conv_done = 1'b0;
               while (1) begin
                  @(negedge clk);
                  if (in_burst && !conv_start) restart_gap_bad++;
                  if (!conv_start) break;
                  begin
                     int k3;
                     k3 = n_starts;
                     n_starts++;
                     prod[k3] = val_of(k3);
                     repeat (CONV_CYC - 1) @(posedge clk);
                     #1 conv_done = 1'b1;
                     conv_result = 10'(prod[k3]);
                     @(posedge clk);
                     #1 conv_done = 1'b0;
                  end
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_byte = b;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic wait_bytes(input int target, input int limit);
      for (int i = 0; i < limit && rx_n < target; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   initial begin
      int base, k0, s0, cmd, v, idx, lastk;
      bit found;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R12: command during the power-on hold is ignored
      repeat (5) @(posedge clk);
      send(8'hC3);
      repeat (POR + 60) @(negedge clk);
      check(rx_n == 0, "R12 no echo in hold", rx_n, 0);
      check(n_starts == 0, "R12 no start in hold", n_starts, 0);
      // R2 reset state
      check(chan_sel == 2'b11 && ref_supply && gain_unity, "R2 default cfg",
            {chan_sel, ref_supply, gain_unity}, 4'hF);
      check(!rsp_valid && !conv_start, "R2 idle outputs", {rsp_valid, conv_start}, 0);

      // R3 R4 R5 demand sweep
      for (int ch = 0; ch < 3; ch++) begin
         for (int rg = 0; rg < 4; rg++) begin
            cmd = 192 + ch * 16 + (rg / 2) * 8 + ((ch + rg) % 2) * 4 + 2 + (rg % 2);
            base = rx_n; k0 = n_starts;
            send(8'(cmd));
            wait_bytes(base + 3, 400);
            repeat (3 * CONV_CYC) @(negedge clk);
            v = val_of(k0);
            check(rx_n == base + 3, "R4 three bytes", rx_n - base, 3);
            check(rx[base] == 8'(cmd), "R4 echo", rx[base], cmd);
            check(rx[base+1] == 8'(hi_exp(ch, v)), "R5 high byte", rx[base+1], hi_exp(ch, v));
            check(rx[base+2] == 8'(lo_exp(v)), "R5 low byte", rx[base+2], lo_exp(v));
            check(n_starts == k0 + 1, "R4 one start", n_starts - k0, 1);
            check(chan_sel == 2'(ch) && ref_supply == (rg / 2 == 1) && gain_unity == (rg % 2 == 1),
                  "R3 decode", {chan_sel, ref_supply, gain_unity}, ch * 4 + (rg / 2) * 2 + rg % 2);
         end
      end

      // R6 channel 11 demand: echo only
      base = rx_n; k0 = n_starts;
      send(8'hF2);
      repeat (200) @(negedge clk);
      check(rx_n == base + 1 && rx[base] == 8'hF2, "R6 echo only", rx_n - base, 1);
      check(n_starts == k0, "R6 no start", n_starts - k0, 0);
      check(chan_sel == 2'b11 && !ref_supply && !gain_unity, "R6 cfg taken",
            {chan_sel, ref_supply, gain_unity}, 4'hC);

      // R1 bad prefix ignored
      base = rx_n; k0 = n_starts;
      send(8'h73);
      send(8'h8B);
      repeat (200) @(negedge clk);
      check(rx_n == base, "R1 no echo", rx_n - base, 0);
      check(n_starts == k0, "R1 no start", n_starts - k0, 0);
      check(chan_sel == 2'b11 && !gain_unity, "R1 cfg unchanged", {chan_sel, gain_unity}, 6);

      // R7 burst on channel 1
      base = rx_n; k0 = n_starts;
      in_burst = 1;
      send(8'hD9);
      wait_bytes(base + 9, 2000);
      check(rx[base] == 8'hD9, "R7 burst echo", rx[base], 8'hD9);
      for (int p = 0; p < 4; p++) begin
         v = val_of(k0 + p);
         check(rx[base+1+2*p] == 8'(hi_exp(1, v)), "R7 burst high", rx[base+1+2*p], hi_exp(1, v));
         check(rx[base+2+2*p] == 8'(lo_exp(v)), "R7 burst low", rx[base+2+2*p], lo_exp(v));
      end
      check(restart_gap_bad == 0, "R7 back-to-back", restart_gap_bad, 0);

      // R8 demand command during burst ends it
      in_burst = 0;
      repeat (5) @(negedge clk);
      base = rx_n;
      send(8'hCB);
      repeat (6 * CONV_CYC) @(negedge clk);
      s0 = n_starts;
      repeat (200) @(negedge clk);
      check(n_starts == s0, "R8 burst stopped", n_starts - s0, 0);
      v = prod[n_starts - 1];
      check(rx[rx_n-2] == 8'(hi_exp(0, v)) && rx[rx_n-1] == 8'(lo_exp(v)), "R8 new pair",
            rx[rx_n-2], hi_exp(0, v));
      v = prod[n_starts - 2];
      check(rx[rx_n-4] == 8'(hi_exp(1, v)), "R8 in-flight pair old tag", rx[rx_n-4], hi_exp(1, v));
      found = 0;
      for (int i = base; i < rx_n - 4; i++) if (rx[i] == 8'hCB) found = 1;
      check(found, "R9 echo before new pair", int'(found), 1);

      // R10 stall keeps newest result, R9 echo before pending pair
      ready_mode = 1;
      repeat (3) @(negedge clk);
      base = rx_n; k0 = n_starts;
      send(8'hE9);
      for (int i = 0; i < 2000 && n_starts < k0 + 5; i++) @(negedge clk);
      send(8'hF3);
      repeat (4 * CONV_CYC) @(negedge clk);
      lastk = n_starts - 1;
      ready_mode = 0;
      wait_bytes(base + 4, 100);
      repeat (50) @(negedge clk);
      v = prod[lastk];
      check(rx_n == base + 4, "R10 only newest kept", rx_n - base, 4);
      check(rx[base] == 8'hE9 && rx[base+1] == 8'hF3, "R9 echoes first", rx[base+1], 8'hF3);
      check(rx[base+2] == 8'(hi_exp(2, v)), "R10 newest high", rx[base+2], hi_exp(2, v));
      check(rx[base+3] == 8'(lo_exp(v)), "R10 newest low", rx[base+3], lo_exp(v));

      // R10 R11 throttled burst: every high byte paired with its own low
      base = rx_n; k0 = n_starts;
      ready_mode = 2;
      send(8'hC9);
      repeat (700) @(negedge clk);
      send(8'hF3);
      repeat (4 * CONV_CYC) @(negedge clk);
      ready_mode = 0;
      repeat (60) @(negedge clk);
      lastk = k0 - 1;
      idx = base;
      while (idx < rx_n) begin
         if (rx[idx][7:6] == 2'b11) begin
            idx++;
         end else if (rx[idx][7:6] == 2'b10) begin
            int hv;
            bit ok;
            ok = 0;
            if (idx + 1 < rx_n && rx[idx+1][7] == 1'b0 && rx[idx+1][0] == 1'b0) begin
               hv = int'(rx[idx][3:0]) * 64 + int'(rx[idx+1][6:1]);
               for (int k = lastk + 1; k < n_starts && !ok; k++)
                  if (prod[k] == hv) begin ok = 1; lastk = k; end
            end
            check(ok && rx[idx][5:4] == 2'b00, "R10 pair integrity", rx[idx], 0);
            idx += 2;
         end else begin
            check(0, "R10 orphan low byte", rx[idx], 0);
            idx++;
         end
      end
      check(lastk == n_starts - 1, "R10 last result delivered", lastk, n_starts - 1);

      // R2 reset mid-burst
      in_burst = 0;
      send(8'hD9);
      repeat (50) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (POR + 100) @(negedge clk);
      base = rx_n; s0 = n_starts;
      repeat (100) @(negedge clk);
      check(n_starts == s0 && rx_n == base, "R2 idle after reset", n_starts - s0, 0);
      check(chan_sel == 2'b11 && ref_supply && gain_unity, "R2 defaults restored",
            {chan_sel, ref_supply, gain_unity}, 4'hF);

      finish_run();
   end
endmodule